// File: doc/BRIEF.md
# Flash Window Bus Bridge

This block connects an asynchronous byte-wide host port to a parallel flash device. The host presents a 24-bit address and active-low chip-enable, output-enable and write-enable strobes. The bridge samples those strobes into its own clock domain and captures the host address when the chip-enable is seen low. It decides whether the captured address falls inside a fixed ROM window, given by a base and a mask, and drives a 21-bit byte address to the flash. It then replays the strobes on the flash side and steers the two data paths: flash to host for reads, and host to flash for writes.

By default the ROM window is read-only. A write into the window pulses the flash write-enable but leaves the flash chip-enable high. When the `prog_en` input is high, the flash chip-enable becomes the active-low AND of the bridge's own chip-enable and write-enable. Reads behave exactly as before, and a write asserts both strobes at once, so the flash accepts command and program cycles. The flash output-enable is forced high whenever the flash write-enable is low.

The controller has six states. IDLE has no access in progress. DECODE holds a captured address while waiting for a read or write strobe. RD_SETUP has flash CE low. RD_ACTIVE has flash CE and OE low and the host bus driven. WR_ACTIVE has flash WE low and the flash bus driven. MISS is an access outside the window.

The transitions are as follows:
- IDLE→DECODE when the synchronised CE is low; the address is captured at this step.
- DECODE→MISS when the address is outside the window.
- DECODE→WR_ACTIVE when WE is low.
- DECODE→RD_SETUP when OE is low.
- RD_SETUP→RD_ACTIVE when OE stays low.
- RD_ACTIVE→RD_SETUP when OE rises.
- RD_SETUP or RD_ACTIVE→WR_ACTIVE when WE falls.
- WR_ACTIVE→DECODE when WE rises with CE still low.
- Any state→IDLE when CE rises.

Top module: `flash_window_bridge`

## Requirements
- R1: After reset, and whenever host CE is high, flash CE, OE and WE are all high (1) and neither data path is driven (`host_data_oe`=0, `flash_data_oe`=0).
- R2: The host address is captured when the synchronised host CE is first seen low. `flash_addr` equals that captured address bits [20:0] ANDed with `ADDR_MASK`, and it holds while CE stays low even if the host address changes.
- R3: A host strobe change reaches the flash strobes on the third rising clock edge after it is applied (two synchroniser stages plus the state register).
- R4: On a read inside the window, flash CE goes low one cycle before flash OE goes low.
- R5: During a read, `host_data_out` equals `flash_data_in` and `host_data_oe`=1 while flash OE is low. Once host CE returns high, `host_data_oe` returns to 0.
- R6: During a write inside the window, flash WE is low, `flash_data_out` equals `host_data_in` and `flash_data_oe`=1. Raising host WE with CE still low ends the write drive and raises flash WE.
- R7: With `prog_en`=0, a write into the window leaves flash CE high.
- R8: With `prog_en`=1, a write into the window pulls flash CE low in the same cycle as flash WE, and reads are unchanged.
- R9: Flash OE is never low while flash WE is low. When host OE and WE are both low, the cycle is treated as a write.
- R10: An access with `(addr & WIN_MASK) != WIN_BASE` (default window 0x200000–0x3FFFFF) leaves all flash strobes high and drives no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | 1 = write-gated flash CE (programming), 0 = read-only window |
| host_addr | input | 24 | Host address |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_oe_n | input | 1 | Host output-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| host_data_in | input | 8 | Data written by the host |
| host_data_out | output | 8 | Read data returned to the host |
| host_data_oe | output | 1 | Drive enable for host data bus |
| flash_addr | output | 21 | Flash byte address |
| flash_ce_n | output | 1 | Flash chip-enable, active low |
| flash_oe_n | output | 1 | Flash output-enable, active low |
| flash_we_n | output | 1 | Flash write-enable, active low |
| flash_data_in | input | 8 | Data returned by the flash |
| flash_data_out | output | 8 | Data driven to the flash |
| flash_data_oe | output | 1 | Drive enable for flash data bus |

## Verification
Every host strobe change is applied on a falling clock edge. It reaches the flash strobes after exactly three rising edges: two synchroniser stages and then the state register. The step from RD_SETUP to RD_ACTIVE adds one more edge before flash OE falls. The latency checks sample one nanosecond after the second rising edge, where the old value must still be present, and after the third, where the new value must appear. Steady-state checks sample after the fixed three- or four-edge count, never at an edge. Data path values are combinational from the state, so they are checked in the same sample as the strobes.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DECODE    = 3'd1,
        ST_RD_SETUP  = 3'd2,
        ST_RD_ACTIVE = 3'd3,
        ST_WR_ACTIVE = 3'd4,
        ST_MISS      = 3'd5
    } fwb_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } fwb_strobes_t;

endpackage

// File: rtl/fwb_sync.sv
module fwb_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_n,
    output logic [WIDTH-1:0] dout_n
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= '1;
                end else if (g == 0) begin
                    chain[g] <= din_n;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign dout_n = chain[STAGES-1];

endmodule

// File: rtl/fwb_window.sv
module fwb_window #(
    parameter int          HOST_AW  = 24,
    parameter int          FLASH_AW = 21,
    parameter logic [23:0] WIN_BASE = 24'h200000,
    parameter logic [23:0] WIN_MASK = 24'hE00000,
    parameter logic [20:0] ADDR_MASK = 21'h1FFFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [HOST_AW-1:0]  host_addr,
    output logic                hit,
    output logic [FLASH_AW-1:0] flash_addr
);

    logic [HOST_AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (capture) begin
            addr_q <= host_addr;
        end
    end

    assign hit        = ((addr_q & WIN_MASK[HOST_AW-1:0]) == WIN_BASE[HOST_AW-1:0]);
    assign flash_addr = addr_q[FLASH_AW-1:0] & ADDR_MASK[FLASH_AW-1:0];

endmodule

// File: rtl/fwb_fsm.sv
module fwb_fsm
    import fwb_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_act,
    input  logic         oe_act,
    input  logic         we_act,
    input  logic         hit,
    output logic         capture,
    output fwb_strobes_t brg,
    output logic         rd_drive,
    output logic         wr_drive
);

    fwb_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ce_act) state_d = ST_DECODE;
            end
            ST_DECODE: begin
                if (!ce_act)      state_d = ST_IDLE;
                else if (!hit)    state_d = ST_MISS;
                else if (we_act)  state_d = ST_WR_ACTIVE;
                else if (oe_act)  state_d = ST_RD_SETUP;
            end
            ST_RD_SETUP: begin
                if (!ce_act)      state_d = ST_IDLE;
                else if (we_act)  state_d = ST_WR_ACTIVE;
                else if (oe_act)  state_d = ST_RD_ACTIVE;
            end
            ST_RD_ACTIVE: begin
                if (!ce_act)      state_d = ST_IDLE;
                else if (we_act)  state_d = ST_WR_ACTIVE;
                else if (!oe_act) state_d = ST_RD_SETUP;
            end
            ST_WR_ACTIVE: begin
                if (!ce_act)      state_d = ST_IDLE;
                else if (!we_act) state_d = ST_DECODE;
            end
            ST_MISS: begin
                if (!ce_act)      state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture  = (state_q == ST_IDLE) && ce_act;
        brg.ce_n = !((state_q == ST_RD_SETUP) || (state_q == ST_RD_ACTIVE));
        brg.oe_n = !(state_q == ST_RD_ACTIVE);
        brg.we_n = !(state_q == ST_WR_ACTIVE);
        rd_drive = (state_q == ST_RD_ACTIVE);
        wr_drive = (state_q == ST_WR_ACTIVE);
    end

endmodule

// File: rtl/flash_window_bridge.sv
module flash_window_bridge
    import fwb_pkg::*;
#(
    parameter int          HOST_AW     = 24,
    parameter int          FLASH_AW    = 21,
    parameter int          DW          = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [23:0] WIN_BASE    = 24'h200000,
    parameter logic [23:0] WIN_MASK    = 24'hE00000,
    parameter logic [20:0] ADDR_MASK   = 21'h1FFFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_en,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic                host_ce_n,
    input  logic                host_oe_n,
    input  logic                host_we_n,
    input  logic [DW-1:0]       host_data_in,
    output logic [DW-1:0]       host_data_out,
    output logic                host_data_oe,
    output logic [FLASH_AW-1:0] flash_addr,
    output logic                flash_ce_n,
    output logic                flash_oe_n,
    output logic                flash_we_n,
    input  logic [DW-1:0]       flash_data_in,
    output logic [DW-1:0]       flash_data_out,
    output logic                flash_data_oe
);

    localparam int NSTROBE = 3;

    logic [NSTROBE-1:0] raw_n, syn_n;
    logic               capture, hit, rd_drive, wr_drive;
    fwb_strobes_t       brg;

    assign raw_n = {host_ce_n, host_oe_n, host_we_n};

    fwb_sync #(.WIDTH(NSTROBE), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_n  (raw_n),
        .dout_n (syn_n)
    );

    fwb_window #(
        .HOST_AW   (HOST_AW),
        .FLASH_AW  (FLASH_AW),
        .WIN_BASE  (WIN_BASE),
        .WIN_MASK  (WIN_MASK),
        .ADDR_MASK (ADDR_MASK)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .host_addr  (host_addr),
        .hit        (hit),
        .flash_addr (flash_addr)
    );

    fwb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_act   (!syn_n[2]),
        .oe_act   (!syn_n[1]),
        .we_act   (!syn_n[0]),
        .hit      (hit),
        .capture  (capture),
        .brg      (brg),
        .rd_drive (rd_drive),
        .wr_drive (wr_drive)
    );

    always_comb begin
        flash_ce_n     = prog_en ? (brg.ce_n & brg.we_n) : brg.ce_n;
        flash_we_n     = brg.we_n;
        flash_oe_n     = brg.oe_n | !brg.we_n;
        host_data_out  = flash_data_in;
        host_data_oe   = rd_drive;
        flash_data_out = host_data_in;
        flash_data_oe  = wr_drive;
    end

endmodule

// File: rtl/flash_window_bridge_chk.sv
module flash_window_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        prog_en,
    input logic        host_ce_n,
    input logic        host_data_oe,
    input logic        flash_data_oe,
    input logic [20:0] flash_addr,
    input logic        flash_ce_n,
    input logic        flash_oe_n,
    input logic        flash_we_n
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(host_ce_n, 3)) |-> (flash_ce_n && flash_oe_n && flash_we_n && !host_data_oe && !flash_data_oe)); // R1
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !flash_ce_n && $past(!flash_ce_n)) |-> $stable(flash_addr)); // R2
    AST_CE_BEFORE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && $fell(flash_oe_n)) |-> $past(!flash_ce_n)); // R4
    AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_oe |-> (!flash_oe_n && !flash_ce_n)); // R5
    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        flash_data_oe |-> (!flash_we_n && !host_data_oe)); // R6
    AST_READONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_en && !flash_we_n) |-> flash_ce_n); // R7
    AST_PROG_WRITE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !flash_we_n) |-> !flash_ce_n); // R8
    AST_NO_OE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_we_n |-> flash_oe_n); // R9

endmodule

bind flash_window_bridge flash_window_bridge_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_en       (prog_en),
    .host_ce_n     (host_ce_n),
    .host_data_oe  (host_data_oe),
    .flash_data_oe (flash_data_oe),
    .flash_addr    (flash_addr),
    .flash_ce_n    (flash_ce_n),
    .flash_oe_n    (flash_oe_n),
    .flash_we_n    (flash_we_n)
);

// File: tb/flash_window_bridge_test.sv
`timescale 1ns/1ps
module flash_window_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_en = 1'b0;
    logic [23:0] host_addr = '0;
    logic        host_ce_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
    logic [7:0]  host_data_in = '0;
    logic [7:0]  host_data_out;
    logic        host_data_oe;
    logic [20:0] flash_addr;
    logic        flash_ce_n, flash_oe_n, flash_we_n;
    logic [7:0]  flash_data_in;
    logic [7:0]  flash_data_out;
    logic        flash_data_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign flash_data_in = flash_addr[7:0] ^ 8'h5A;

    flash_window_bridge uut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .host_addr(host_addr),
        .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .host_data_in(host_data_in), .host_data_out(host_data_out),
        .host_data_oe(host_data_oe), .flash_addr(flash_addr),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
        .flash_data_in(flash_data_in), .flash_data_out(flash_data_out),
        .flash_data_oe(flash_data_oe)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic ce, input logic oe, input logic we);
        @(negedge clk);
        host_ce_n = ce; host_oe_n = oe; host_we_n = we;
    endtask

    task automatic end_access();
        drive(1'b1, 1'b1, 1'b1);
        edges(3);
    endtask

    task automatic t_reset();
        chk("R1", "reset strobes", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
        chk("R1", "reset drives", {host_data_oe, flash_data_oe}, 2'b00);
    endtask

    task automatic t_read(input logic [23:0] a, input logic pe);
        prog_en = pe;
        @(negedge clk); host_addr = a;
        drive(1'b0, 1'b1, 1'b1);
        edges(3);
        chk("R3", "decode keeps strobes", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
        drive(1'b0, 1'b0, 1'b1);
        edges(2);
        chk("R3", "ce not yet low at edge 2", flash_ce_n, 1'b1);
        edges(1);
        chk("R4", "ce low oe high", {flash_ce_n, flash_oe_n}, 2'b01);
        chk("R2", "flash addr", flash_addr, a[20:0]);
        edges(1);
        chk(pe ? "R8" : "R4", "ce and oe low", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b001);
        chk("R5", "read data", host_data_out, a[7:0] ^ 8'h5A);
        chk("R5", "host drive on", {host_data_oe, flash_data_oe}, 2'b10);
        end_access();
        chk("R5", "host drive released", host_data_oe, 1'b0);
        chk("R1", "strobes high after read", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
    endtask

    task automatic t_addr_hold();
        prog_en = 1'b0;
        @(negedge clk); host_addr = 24'h2ABCDE;
        drive(1'b0, 1'b0, 1'b1);
        edges(5);
        @(negedge clk); host_addr = 24'h212345;
        edges(3);
        chk("R2", "addr held", flash_addr, 21'h0ABCDE);
        chk("R2", "read data of held addr", host_data_out, 8'hDE ^ 8'h5A);
        end_access();
    endtask

    task automatic t_write(input logic pe);
        prog_en = pe;
        @(negedge clk); host_addr = 24'h200AAA; host_data_in = 8'hA5;
        drive(1'b0, 1'b1, 1'b1);
        edges(3);
        drive(1'b0, 1'b1, 1'b0);
        edges(2);
        chk("R3", "we not yet low at edge 2", flash_we_n, 1'b1);
        edges(1);
        chk("R6", "flash we low", flash_we_n, 1'b0);
        chk("R6", "flash data", flash_data_out, 8'hA5);
        chk("R6", "flash drive on", {flash_data_oe, host_data_oe}, 2'b10);
        chk("R9", "oe high in write", flash_oe_n, 1'b1);
        if (pe) chk("R8", "ce low with we", flash_ce_n, 1'b0);
        else    chk("R7", "ce high in readonly write", flash_ce_n, 1'b1);
        drive(1'b0, 1'b1, 1'b1);
        edges(3);
        chk("R6", "we released with ce low", {flash_we_n, flash_data_oe}, 2'b10);
        chk("R6", "ce high after write", flash_ce_n, 1'b1);
        end_access();
    endtask

    task automatic t_both_low();
        prog_en = 1'b1;
        @(negedge clk); host_addr = 24'h200555; host_data_in = 8'h55;
        drive(1'b0, 1'b1, 1'b1);
        edges(3);
        drive(1'b0, 1'b0, 1'b0);
        edges(3);
        chk("R9", "both low gives write", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b010);
        chk("R9", "write drive", {flash_data_oe, host_data_oe}, 2'b10);
        end_access();
    endtask

    task automatic t_miss(input logic pe);
        prog_en = pe;
        @(negedge clk); host_addr = 24'h400010;
        drive(1'b0, 1'b1, 1'b1);
        edges(3);
        drive(1'b0, 1'b0, 1'b1);
        edges(5);
        chk("R10", "miss read strobes", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
        chk("R10", "miss read drives", {host_data_oe, flash_data_oe}, 2'b00);
        drive(1'b0, 1'b1, 1'b0);
        edges(5);
        chk("R10", "miss write strobes", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
        chk("R10", "miss write drives", {host_data_oe, flash_data_oe}, 2'b00);
        end_access();
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        edges(3);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        edges(2);
        t_reset();
        t_read(24'h2001A7, 1'b0);
        t_read(24'h3FFFFF, 1'b1);
        t_addr_hold();
        t_write(1'b0);
        t_write(1'b1);
        t_both_low();
        t_miss(1'b0);
        t_miss(1'b1);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule